// File: doc/BRIEF.md
# Debug Serial Port Status Register

This block holds the eight-bit status word of a small debug serial port. It collects event strobes from the receive and transmit datapaths and turns them into sticky flags: receive-data-full, receive overrun, framing error, break detected, transmit-holding-empty and transmit collision. It also shows the busy states of the receiver and the transmitter. Software reads the word and clears flags by writing ones. Bit 3 works the other way: writing one there sets the transmit-empty flag and aborts a held byte. A receive-data read strobe clears the data-full flag.

A counter on the sampled receive line detects a break. It counts consecutive low bits, saturates, and raises the break flag once per low stretch. The counter re-arms after a high bit. Every status bit and the abort pulse are registered, so a cause seen at one rising edge shows at the outputs right after that edge.

Top module: `dbgu_status`

## Requirements
- R1: The status word has this layout, MSB first: data-full[7], overrun[6], framing[5], break[4], tx-empty[3], collision[2], rx-busy[1], tx-busy[0]. After synchronous reset it reads 0x08 and `tx_abort` is 0.
- R2: Bit 7 is set one cycle after `rx_byte_load` or `rx_host_wr`. It is cleared one cycle after `rx_host_rd`, or after a status write with bit 7 at one.
- R3: Bit 6 is set when `rx_byte_load` or `rx_host_wr` arrives while bit 7 is 1 and `rx_host_rd` is low in that cycle. A status write with bit 6 at one clears it.
- R4: Bit 5 is set one cycle after `rx_frame_bad`. A status write with bit 5 at one clears it.
- R5: Bit 4 is set on the 10th consecutive sampled low receive bit (`rx_bit_stb` with `rx_bit_val`=0). Further low bits do not set it again until a sampled high bit resets the count. A status write with bit 4 at one clears it.
- R6: Bit 3 goes to 0 one cycle after `tx_host_wr`. It goes to 1 one cycle after `tx_shift_take`. If both occur in the same cycle, the write wins.
- R7: A status write with bit 3 at one sets bit 3, and this overrides `tx_host_wr`. If bit 3 was 0 at that write, `tx_abort` is high for exactly the next cycle. Otherwise `tx_abort` stays low.
- R8: Bit 2 is set one cycle after `tx_collide`. A status write with bit 2 at one clears it.
- R9: Bits 1 and 0 follow `rx_busy` and `tx_busy` with one cycle of delay. Status writes do not affect them.
- R10: A status write with zero bits has no effect, and flags with no event hold their value.
- R11: When a set event and a software clear hit the same flag in one cycle, the flag ends up set.

Top module port list order is given below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte_load | input | 1 | Received byte moved into receive data register |
| rx_host_wr | input | 1 | Receive data register written directly |
| rx_host_rd | input | 1 | Receive data register read strobe |
| rx_frame_bad | input | 1 | Framing error on received character |
| rx_bit_stb | input | 1 | A receive bit was sampled this cycle |
| rx_bit_val | input | 1 | Level of the sampled receive bit |
| rx_busy | input | 1 | Receiver busy state |
| tx_host_wr | input | 1 | Transmit holding register written |
| tx_shift_take | input | 1 | Held byte moved into transmit shifter |
| tx_collide | input | 1 | Transmit collision event |
| tx_busy | input | 1 | Transmitter busy state |
| stat_wr | input | 1 | Status register write strobe |
| stat_wdata | input | 8 | Status write data |
| stat_q | output | 8 | Status word |
| tx_abort | output | 1 | One-cycle abort of the held transmit byte |

## Verification
Each flag is a single register that drives its output bit directly. A wrong internal state therefore shows on `stat_q` in the cycle right after the edge that caused it, and the bench compares the whole word every cycle. A fault in the break counter stays hidden until the low run reaches ten bits. It then shows as a flag that is early, late or repeated, so directed runs of nine, ten and twenty low bits cover that limit. Abort errors show as a wrong `tx_abort` level in the cycle after a bit-3 write.

// File: rtl/dbgu_pkg.sv
package dbgu_pkg;

    localparam int STAT_W   = 8;
    localparam int BRK_LEN  = 10;

    localparam int B_RDRF   = 7;
    localparam int B_OVR    = 6;
    localparam int B_FERR   = 5;
    localparam int B_BRK    = 4;
    localparam int B_TXE    = 3;
    localparam int B_TCOL   = 2;
    localparam int B_RBUSY  = 1;
    localparam int B_TBUSY  = 0;

    typedef enum logic [1:0] {
        K_STICKY  = 2'd0,
        K_TXEMPTY = 2'd1,
        K_MIRROR  = 2'd2
    } bit_kind_e;

    typedef struct packed {
        logic rdrf;
        logic ovr;
        logic ferr;
        logic brk;
        logic txe;
        logic tcol;
        logic rbusy;
        logic tbusy;
    } stat_t;

    function automatic bit_kind_e kind_of(input int idx);
        if (idx == B_TXE)
            return K_TXEMPTY;
        else if (idx == B_RBUSY || idx == B_TBUSY)
            return K_MIRROR;
        else
            return K_STICKY;
    endfunction

    function automatic logic rst_bit(input int idx);
        return (idx == B_TXE) ? 1'b1 : 1'b0;
    endfunction

    function automatic stat_t w1_mask(input logic wr, input logic [STAT_W-1:0] d);
        return wr ? stat_t'(d) : stat_t'('0);
    endfunction

endpackage

// File: rtl/dbgu_flag.sv
module dbgu_flag #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic q;

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (set_i)
            q <= 1'b1;
        else if (clr_i)
            q <= 1'b0;
    end

    assign q_o = q;

    // R11
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_i |=> q_o);

    // R10
    hold_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_i && !clr_i) |=> $stable(q_o));

    // R10
    clr_only_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !q_o);

endmodule

// File: rtl/dbgu_brk_det.sv
module dbgu_brk_det #(
    parameter int BRK_BITS = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_lvl,
    output logic hit_o
);
    localparam int CW = $clog2(BRK_BITS + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(BRK_BITS);
    localparam logic [CW-1:0] CNT_LAST = CW'(BRK_BITS - 1);

    logic [CW-1:0] low_cnt;
    logic          low_bit;

    assign low_bit = bit_vld && !bit_lvl;
    assign hit_o   = low_bit && (low_cnt == CNT_LAST);

    always_ff @(posedge clk) begin
        if (rst)
            low_cnt <= '0;
        else if (bit_vld) begin
            if (bit_lvl)
                low_cnt <= '0;
            else if (low_cnt != CNT_MAX)
                low_cnt <= low_cnt + 1'b1;
        end
    end

    // R5
    brk_once_chk: assert property (@(posedge clk) disable iff (rst)
        hit_o |=> !hit_o);

    // R5
    brk_sat_chk: assert property (@(posedge clk) disable iff (rst)
        low_cnt <= CNT_MAX);

    // R5
    brk_rearm_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && bit_lvl) |=> (low_cnt == '0));

endmodule

// File: rtl/dbgu_tx_hold.sv
module dbgu_tx_hold (
    input  logic clk,
    input  logic rst,
    input  logic hold_wr,
    input  logic take_i,
    input  logic abort_req,
    output logic txe_o,
    output logic abort_o
);
    logic txe_q;
    logic abort_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            txe_q   <= 1'b1;
            abort_q <= 1'b0;
        end else begin
            abort_q <= abort_req && !txe_q;
            if (abort_req)
                txe_q <= 1'b1;
            else if (hold_wr)
                txe_q <= 1'b0;
            else if (take_i)
                txe_q <= 1'b1;
        end
    end

    assign txe_o   = txe_q;
    assign abort_o = abort_q;

    // R7
    abort_sets_txe_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |-> txe_o);

    // R7
    abort_single_chk: assert property (@(posedge clk) disable iff (rst)
        abort_o |=> !abort_o);

    // R6
    hold_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (hold_wr && !abort_req) |=> !txe_o);

endmodule

// File: rtl/dbgu_status.sv
module dbgu_status
    import dbgu_pkg::*;
#(
    parameter int BRK_BITS = BRK_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_byte_load,
    input  logic              rx_host_wr,
    input  logic              rx_host_rd,
    input  logic              rx_frame_bad,
    input  logic              rx_bit_stb,
    input  logic              rx_bit_val,
    input  logic              rx_busy,
    input  logic              tx_host_wr,
    input  logic              tx_shift_take,
    input  logic              tx_collide,
    input  logic              tx_busy,
    input  logic              stat_wr,
    input  logic [STAT_W-1:0] stat_wdata,
    output logic [STAT_W-1:0] stat_q,
    output logic              tx_abort
);
    stat_t             set_s;
    stat_t             clr_s;
    stat_t             w1;
    logic [STAT_W-1:0] set_v;
    logic [STAT_W-1:0] clr_v;
    logic [STAT_W-1:0] word;
    logic              rx_new;
    logic              brk_hit;
    logic              abort_w;

    assign rx_new = rx_byte_load || rx_host_wr;
    assign w1     = w1_mask(stat_wr, stat_wdata);

    dbgu_brk_det #(
        .BRK_BITS (BRK_BITS)
    ) u_brk (
        .clk     (clk),
        .rst     (rst),
        .bit_vld (rx_bit_stb),
        .bit_lvl (rx_bit_val),
        .hit_o   (brk_hit)
    );

    always_comb begin
        set_s       = '0;
        clr_s       = '0;
        set_s.rdrf  = rx_new;
        clr_s.rdrf  = w1.rdrf || rx_host_rd;
        set_s.ovr   = rx_new && word[B_RDRF] && !rx_host_rd;
        clr_s.ovr   = w1.ovr;
        set_s.ferr  = rx_frame_bad;
        clr_s.ferr  = w1.ferr;
        set_s.brk   = brk_hit;
        clr_s.brk   = w1.brk;
        set_s.txe   = tx_shift_take;
        clr_s.txe   = w1.txe;
        set_s.tcol  = tx_collide;
        clr_s.tcol  = w1.tcol;
        set_s.rbusy = rx_busy;
        set_s.tbusy = tx_busy;
    end

    assign set_v = set_s;
    assign clr_v = clr_s;

    for (genvar i = 0; i < STAT_W; i++) begin : g_bit
        if (kind_of(i) == K_STICKY) begin : g_sticky
            dbgu_flag #(
                .RST_VAL (rst_bit(i))
            ) u_flag (
                .clk   (clk),
                .rst   (rst),
                .set_i (set_v[i]),
                .clr_i (clr_v[i]),
                .q_o   (word[i])
            );
        end else if (kind_of(i) == K_TXEMPTY) begin : g_txe
            dbgu_tx_hold u_txh (
                .clk       (clk),
                .rst       (rst),
                .hold_wr   (tx_host_wr),
                .take_i    (set_v[i]),
                .abort_req (clr_v[i]),
                .txe_o     (word[i]),
                .abort_o   (abort_w)
            );
        end else begin : g_mirror
            logic m_q;
            always_ff @(posedge clk) begin
                if (rst)
                    m_q <= rst_bit(i);
                else
                    m_q <= set_v[i] && !clr_v[i];
            end
            assign word[i] = m_q;
        end
    end

    assign stat_q   = word;
    assign tx_abort = abort_w;

    // R9
    busy_mirror_chk: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (stat_q[B_RBUSY] == $past(rx_busy)) && (stat_q[B_TBUSY] == $past(tx_busy)));

    // R2
    rdrf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (rx_byte_load || rx_host_wr) |=> stat_q[B_RDRF]);

    // R3
    overrun_chk: assert property (@(posedge clk) disable iff (rst)
        ((rx_byte_load || rx_host_wr) && stat_q[B_RDRF] && !rx_host_rd) |=> stat_q[B_OVR]);

    // R7
    abort_cause_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_wr && stat_wdata[B_TXE] && !stat_q[B_TXE]) |=> tx_abort);

endmodule

// File: tb/dbgu_status_bench.sv
module dbgu_status_bench;

    logic       clk = 1'b0;
    logic       rst;
    logic       rx_byte_load, rx_host_wr, rx_host_rd, rx_frame_bad;
    logic       rx_bit_stb, rx_bit_val, rx_busy;
    logic       tx_host_wr, tx_shift_take, tx_collide, tx_busy;
    logic       stat_wr;
    logic [7:0] stat_wdata;
    logic [7:0] stat_q;
    logic       tx_abort;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [7:0] m_st;
    logic       m_ab;
    int         m_cnt;

    always #5 clk = ~clk;

    dbgu_status u_dbgu_status (
        .clk           (clk),
        .rst           (rst),
        .rx_byte_load  (rx_byte_load),
        .rx_host_wr    (rx_host_wr),
        .rx_host_rd    (rx_host_rd),
        .rx_frame_bad  (rx_frame_bad),
        .rx_bit_stb    (rx_bit_stb),
        .rx_bit_val    (rx_bit_val),
        .rx_busy       (rx_busy),
        .tx_host_wr    (tx_host_wr),
        .tx_shift_take (tx_shift_take),
        .tx_collide    (tx_collide),
        .tx_busy       (tx_busy),
        .stat_wr       (stat_wr),
        .stat_wdata    (stat_wdata),
        .stat_q        (stat_q),
        .tx_abort      (tx_abort)
    );

    function automatic string req_of(input int b);
        case (b)
            7: return "R2";
            6: return "R3";
            5: return "R4";
            4: return "R5";
            3: return "R6";
            2: return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic idle();
        rx_byte_load = 0; rx_host_wr = 0; rx_host_rd = 0; rx_frame_bad = 0;
        rx_bit_stb = 0; rx_bit_val = 1; rx_busy = 0;
        tx_host_wr = 0; tx_shift_take = 0; tx_collide = 0; tx_busy = 0;
        stat_wr = 0; stat_wdata = 8'h00;
    endtask

    function automatic void model_step();
        logic [7:0] n;
        logic [7:0] w;
        logic       nb;
        n  = m_st;
        w  = stat_wr ? stat_wdata : 8'h00;
        if (rst) begin
            m_st = 8'h08; m_ab = 0; m_cnt = 0;
            return;
        end
        nb = rx_byte_load | rx_host_wr;
        if (nb) n[7] = 1; else if (rx_host_rd | w[7]) n[7] = 0;
        if (nb & m_st[7] & ~rx_host_rd) n[6] = 1; else if (w[6]) n[6] = 0;
        if (rx_frame_bad) n[5] = 1; else if (w[5]) n[5] = 0;
        if (rx_bit_stb & ~rx_bit_val & (m_cnt == 9)) n[4] = 1; else if (w[4]) n[4] = 0;
        if (rx_bit_stb) begin
            if (rx_bit_val) m_cnt = 0;
            else if (m_cnt < 10) m_cnt++;
        end
        m_ab = w[3] & ~m_st[3];
        if (w[3]) n[3] = 1; else if (tx_host_wr) n[3] = 0; else if (tx_shift_take) n[3] = 1;
        if (tx_collide) n[2] = 1; else if (w[2]) n[2] = 0;
        n[1] = rx_busy;
        n[0] = tx_busy;
        m_st = n;
    endfunction

    task automatic step();
        model_step();
        @(posedge clk);
        @(negedge clk);
        for (int b = 0; b < 8; b++)
            chk(stat_q[b] === m_st[b], req_of(b), stat_q[b], m_st[b]);
        chk(tx_abort === m_ab, "R7", tx_abort, m_ab);
    endtask

    task automatic wr_stat(input logic [7:0] d);
        stat_wr = 1; stat_wdata = d; step(); stat_wr = 0; stat_wdata = 0;
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        seed = 32'h5eed_1234;
        void'($urandom(seed));
        idle();
        rst = 1;
        m_st = 8'h08; m_ab = 0; m_cnt = 0;
        @(negedge clk);
        step(); step();
        rst = 0;
        // R1 reset value
        chk(stat_q == 8'h08, "R1", stat_q, 8'h08);
        chk(tx_abort == 1'b0, "R1", tx_abort, 0);

        // R5: nine lows then the tenth
        rx_bit_stb = 1; rx_bit_val = 0;
        for (int k = 0; k < 9; k++) step();
        chk(stat_q[4] == 1'b0, "R5", stat_q[4], 0);
        step();
        chk(stat_q[4] == 1'b1, "R5", stat_q[4], 1);
        rx_bit_stb = 0;
        wr_stat(8'h10);
        rx_bit_stb = 1;
        for (int k = 0; k < 10; k++) step();
        chk(stat_q[4] == 1'b0, "R5", stat_q[4], 0);
        rx_bit_val = 1; step(); rx_bit_val = 0;
        for (int k = 0; k < 10; k++) step();
        chk(stat_q[4] == 1'b1, "R5", stat_q[4], 1);
        rx_bit_stb = 0; rx_bit_val = 1;
        wr_stat(8'h10);

        // R2 / R3 overrun
        rx_byte_load = 1; step(); step(); rx_byte_load = 0;
        chk(stat_q[7:6] == 2'b11, "R3", stat_q[7:6], 3);
        rx_host_rd = 1; step(); rx_host_rd = 0;
        chk(stat_q[7] == 1'b0, "R2", stat_q[7], 0);
        wr_stat(8'h40);
        chk(stat_q[6] == 1'b0, "R3", stat_q[6], 0);

        // R11 set wins over clear
        rx_frame_bad = 1; stat_wr = 1; stat_wdata = 8'h20; step();
        idle();
        chk(stat_q[5] == 1'b1, "R11", stat_q[5], 1);

        // R10 writing zeros
        wr_stat(8'h00);
        chk(stat_q[5] == 1'b1, "R10", stat_q[5], 1);
        wr_stat(8'h20);
        chk(stat_q[5] == 1'b0, "R4", stat_q[5], 0);

        // R6 / R7 abort
        tx_host_wr = 1; step(); tx_host_wr = 0;
        chk(stat_q[3] == 1'b0, "R6", stat_q[3], 0);
        wr_stat(8'h08);
        chk(tx_abort == 1'b1, "R7", tx_abort, 1);
        chk(stat_q[3] == 1'b1, "R7", stat_q[3], 1);
        wr_stat(8'h08);
        chk(tx_abort == 1'b0, "R7", tx_abort, 0);

        // R8 collision, R9 busy ignores writes
        tx_collide = 1; rx_busy = 1; step(); tx_collide = 0;
        chk(stat_q[2] == 1'b1, "R8", stat_q[2], 1);
        wr_stat(8'hFF);
        chk(stat_q[1] == 1'b1, "R9", stat_q[1], 1);
        idle();
        step();

        // random mix
        for (int c = 0; c < 4000; c++) begin
            rx_byte_load  = ($urandom % 8) == 0;
            rx_host_wr    = ($urandom % 32) == 0;
            rx_host_rd    = ($urandom % 6) == 0;
            rx_frame_bad  = ($urandom % 20) == 0;
            rx_bit_stb    = ($urandom % 2) == 0;
            rx_bit_val    = ($urandom % 16) == 0;
            rx_busy       = $urandom % 2;
            tx_host_wr    = ($urandom % 6) == 0;
            tx_shift_take = ($urandom % 6) == 0;
            tx_collide    = ($urandom % 20) == 0;
            tx_busy       = $urandom % 2;
            stat_wr       = ($urandom % 5) == 0;
            stat_wdata    = 8'($urandom) & 8'($urandom);
            step();
        end
        idle();
        step();

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule